// File: doc/BRIEF.md
# Programmable Delay-Line Sequencer

This block sequences the pointer-reset and enable controls of a dual-pointer line buffer so that the buffer acts as a fixed delay of n clocks. The buffer's write and read sides share one clock. Each buffer pointer steps once per enabled clock edge and wraps after `MAX_LEN` addresses. A pointer-reset control makes that edge use address 0. A software-held length n is range-checked against a minimum, and that minimum depends on how fast the clock runs. On a start pulse the sequencer captures n and one of three sequencing schemes, then drives the four controls until the next start.

The three schemes give the same delay by different means:
- **Joint mode** pulses both resets together every n steps.
- **Offset mode** pulses the write reset first and the read reset n steps later.
- **Hold mode** pulses both resets once and keeps reads disabled for the first n steps.

An output-valid flag tells the consumer when the buffer output first carries a delayed word.

**State machine.** The sequencer has four states:
- `ST_IDLE`: after reset, no controls active. It goes to `ST_PRIME` on start.
- `ST_PRIME`: steps 0 to n−1. It goes to `ST_ALIGN` when the lap counter reaches n−1.
- `ST_ALIGN`: step n, one cycle. It goes to `ST_STEADY`.
- `ST_STEADY`: steps after n, and it remains there.

A start pulse in any state goes to `ST_PRIME`.

**Step numbering.** Step 0 is the first clock edge after the edge that samples start. Step k is k edges later.

Top module: `line_delay_ctrl`

## Requirements
- R1: After reset and until the first start, `wr_rst`, `rd_rst`, `wr_en`, `rd_en`, `out_valid` and `cfg_err` are all 0.
- R2: A `cfg_load` edge whose `cfg_len` lies in [minimum, `MAX_LEN`] replaces the held length and clears `cfg_err`. The minimum is `MIN_FAST` when `speed_sel`=1 and `MIN_SLOW` when `speed_sel`=0. The held length after reset is `DEF_LEN`.
- R3: A `cfg_load` edge whose `cfg_len` lies outside that range sets `cfg_err` to 1 and leaves the held length unchanged. `cfg_err` stays 1 until an accepted load.
- R4: Start captures `mode` and the held length as they stand before that edge; a load on the same edge or later affects only the next start. A start during a running sequence restarts it at step 0.
- R5: In joint mode (`mode`=0, and reserved `mode`=3 which behaves the same), `wr_rst` and `rd_rst` are both 1 exactly at steps that are multiples of n, and both enables are 1 at every step.
- R6: In joint mode with n = `MAX_LEN`, the joint reset occurs only at step 0 and never repeats.
- R7: In offset mode (`mode`=1), `wr_rst` is 1 only at step 0, `rd_rst` is 1 only at step n, and both enables are 1 at every step.
- R8: In hold mode (`mode`=2), both resets are 1 only at step 0, `wr_en` is 1 at every step, and `rd_en` is 0 for steps 0..n−1 and 1 from step n on.
- R9: `out_valid` is 0 after the edges of steps below n and 1 after the edge of step n and every later step, until the next start.
- R10: A buffer that follows the stated pointer convention returns, after the edge of any step k ≥ n, the word written at step k−n, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both buffer sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Captures length and mode, and (re)starts the sequence |
| mode | input | 2 | 0 joint, 1 offset, 2 hold, 3 reserved (joint) |
| speed_sel | input | 1 | 1 selects the fast-clock minimum length `MIN_FAST`, 0 selects `MIN_SLOW` |
| cfg_load | input | 1 | Presents `cfg_len` for range check and capture |
| cfg_len | input | LW | Requested delay; LW = clog2(MAX_LEN+1) |
| wr_rst | output | 1 | Buffer write pointer to address 0 this edge |
| rd_rst | output | 1 | Buffer read pointer to address 0 this edge |
| wr_en | output | 1 | Buffer write and write-pointer advance this edge |
| rd_en | output | 1 | Buffer read and read-pointer advance this edge |
| out_valid | output | 1 | Buffer output holds a word delayed by n |
| cfg_err | output | 1 | Last length request was rejected |

## Verification
The bench drives a behavioural buffer from the four controls and sweeps every legal n of a small configuration in all four mode codes. At every step it compares the controls, `out_valid` and the delayed word against step arithmetic.

The sweep targets these faults:
- An off-by-one in the lap counter would put the periodic or offset reset one step early or late. It would also shift every output word by one position.
- A full-line case that still re-pulsed the joint reset at step `MAX_LEN` would show up as an extra reset pulse.
- A hold window that ended one step early would read an unwritten cell.

The length range edges are probed under both speed settings, because a wrong minimum would accept a length too short for the buffer. A load that shares an edge with start is probed, and so is a load during a running sequence, because a length that took effect without a restart would corrupt the delay mid-stream.

// File: rtl/line_delay_pkg.sv
package line_delay_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRIME  = 2'd1,
        ST_ALIGN  = 2'd2,
        ST_STEADY = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        MD_JOINT  = 2'd0,
        MD_OFFSET = 2'd1,
        MD_HOLD   = 2'd2,
        MD_RSVD   = 2'd3
    } seq_mode_t;

endpackage

// File: rtl/ldc_cfg.sv
module ldc_cfg #(
    parameter int MAX_LEN  = 5048,
    parameter int MIN_FAST = 21,
    parameter int MIN_SLOW = 15,
    parameter int DEF_LEN  = 5048,
    parameter int LW       = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [LW-1:0] cfg_len,
    input  logic          speed_sel,
    output logic [LW-1:0] held_len,
    output logic          cfg_err
);
    localparam logic [LW-1:0] LIM_HI   = LW'(MAX_LEN);
    localparam logic [LW-1:0] LIM_FAST = LW'(MIN_FAST);
    localparam logic [LW-1:0] LIM_SLOW = LW'(MIN_SLOW);
    localparam logic [LW-1:0] LEN_RST  = LW'(DEF_LEN);

    logic [LW-1:0] lim_lo;
    logic          in_range;

    always_comb begin
        lim_lo   = speed_sel ? LIM_FAST : LIM_SLOW;
        in_range = (cfg_len >= lim_lo) && (cfg_len <= LIM_HI);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_len <= LEN_RST;
            cfg_err  <= 1'b0;
        end else if (cfg_load) begin
            if (in_range) begin
                held_len <= cfg_len;
                cfg_err  <= 1'b0;
            end else begin
                cfg_err  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ldc_seq.sv
module ldc_seq
    import line_delay_pkg::*;
#(
    parameter int DEF_LEN = 5048,
    parameter int LW      = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    mode_in,
    input  logic [LW-1:0] held_len,
    output seq_state_t    state,
    output logic [LW-1:0] phase,
    output logic [LW-1:0] run_len,
    output seq_mode_t     run_mode
);
    localparam logic [LW-1:0] LEN_RST = LW'(DEF_LEN);

    seq_state_t nxt;
    logic       lap_end;

    assign lap_end = (phase == run_len - LW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_PRIME;
            ST_PRIME:  if (start) nxt = ST_PRIME;
                       else if (lap_end) nxt = ST_ALIGN;
            ST_ALIGN:  nxt = start ? ST_PRIME : ST_STEADY;
            ST_STEADY: if (start) nxt = ST_PRIME;
            default:   nxt = ST_IDLE;
        endcase
    end

    // lap counter and captured run parameters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= '0;
            run_len  <= LEN_RST;
            run_mode <= MD_JOINT;
        end else if (start) begin
            phase    <= '0;
            run_len  <= held_len;
            run_mode <= seq_mode_t'(mode_in);
        end else if (state != ST_IDLE) begin
            phase    <= lap_end ? '0 : phase + LW'(1);
        end
    end
endmodule

// File: rtl/ldc_drive.sv
module ldc_drive
    import line_delay_pkg::*;
#(
    parameter int MAX_LEN = 5048,
    parameter int LW      = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_state_t    state,
    input  logic [LW-1:0] phase,
    input  logic [LW-1:0] run_len,
    input  seq_mode_t     run_mode,
    output logic          wr_rst,
    output logic          rd_rst,
    output logic          wr_en,
    output logic          rd_en,
    output logic          out_valid
);
    localparam logic [LW-1:0] LIM_HI = LW'(MAX_LEN);

    logic full_line;
    logic at_zero;
    logic joint;

    assign full_line = (run_len == LIM_HI);
    assign at_zero   = (phase == '0);
    assign joint     = (run_mode == MD_JOINT) || (run_mode == MD_RSVD);

    // control outputs decoded from state
    always_comb begin
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        wr_en  = 1'b0;
        rd_en  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PRIME: begin
                wr_en  = 1'b1;
                rd_en  = (run_mode != MD_HOLD);
                wr_rst = at_zero;
                rd_rst = at_zero && (run_mode != MD_OFFSET);
            end
            ST_ALIGN: begin
                wr_en  = 1'b1;
                rd_en  = 1'b1;
                wr_rst = joint && !full_line;
                rd_rst = (joint && !full_line) || (run_mode == MD_OFFSET);
            end
            ST_STEADY: begin
                wr_en  = 1'b1;
                rd_en  = 1'b1;
                wr_rst = joint && at_zero && !full_line;
                rd_rst = joint && at_zero && !full_line;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= (state == ST_ALIGN) || (state == ST_STEADY);
    end
endmodule

// File: rtl/line_delay_ctrl.sv
module line_delay_ctrl
    import line_delay_pkg::*;
#(
    parameter int MAX_LEN  = 5048,
    parameter int MIN_FAST = 21,
    parameter int MIN_SLOW = 15,
    parameter int DEF_LEN  = 5048,
    localparam int LW      = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic          speed_sel,
    input  logic          cfg_load,
    input  logic [LW-1:0] cfg_len,
    output logic          wr_rst,
    output logic          rd_rst,
    output logic          wr_en,
    output logic          rd_en,
    output logic          out_valid,
    output logic          cfg_err
);
    logic [LW-1:0] held_len;
    logic [LW-1:0] phase;
    logic [LW-1:0] run_len;
    seq_state_t    state;
    seq_mode_t     run_mode;

    ldc_cfg #(
        .MAX_LEN (MAX_LEN),
        .MIN_FAST(MIN_FAST),
        .MIN_SLOW(MIN_SLOW),
        .DEF_LEN (DEF_LEN),
        .LW      (LW)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_len  (cfg_len),
        .speed_sel(speed_sel),
        .held_len (held_len),
        .cfg_err  (cfg_err)
    );

    ldc_seq #(
        .DEF_LEN(DEF_LEN),
        .LW     (LW)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mode_in (mode),
        .held_len(held_len),
        .state   (state),
        .phase   (phase),
        .run_len (run_len),
        .run_mode(run_mode)
    );

    ldc_drive #(
        .MAX_LEN(MAX_LEN),
        .LW     (LW)
    ) u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .phase    (phase),
        .run_len  (run_len),
        .run_mode (run_mode),
        .wr_rst   (wr_rst),
        .rd_rst   (rd_rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .out_valid(out_valid)
    );
endmodule

// File: rtl/line_delay_ctrl_chk.sv
module line_delay_ctrl_chk
    import line_delay_pkg::*;
#(
    parameter int MAX_LEN  = 5048,
    parameter int MIN_FAST = 21,
    parameter int MIN_SLOW = 15,
    parameter int LW       = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          speed_sel,
    input logic          cfg_load,
    input logic [LW-1:0] cfg_len,
    input logic          wr_rst,
    input logic          rd_rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          out_valid,
    input logic          cfg_err,
    input seq_mode_t     run_mode
);
    logic started;
    logic len_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started <= 1'b0;
        else if (start) started <= 1'b1;
    end

    assign len_ok = (int'(cfg_len) >= (speed_sel ? MIN_FAST : MIN_SLOW))
                 && (int'(cfg_len) <= MAX_LEN);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> !(wr_rst || rd_rst || wr_en || rd_en || out_valid));

    p_accept_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && len_ok) |=> !cfg_err);

    p_reject_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && !len_ok) |=> cfg_err);

    p_joint_paired_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (started && (run_mode == MD_JOINT || run_mode == MD_RSVD)) |-> (wr_rst == rd_rst));

    p_enables_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (started && run_mode != MD_HOLD) |-> (wr_en && rd_en));

    p_offset_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (started && run_mode == MD_OFFSET) |-> !(wr_rst && rd_rst));

    p_hold_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (started && run_mode == MD_HOLD && wr_rst) |-> (rd_rst && !rd_en));

    p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $past(start, 2));
endmodule

bind line_delay_ctrl line_delay_ctrl_chk #(
    .MAX_LEN (MAX_LEN),
    .MIN_FAST(MIN_FAST),
    .MIN_SLOW(MIN_SLOW),
    .LW      (LW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .speed_sel(speed_sel),
    .cfg_load (cfg_load),
    .cfg_len  (cfg_len),
    .wr_rst   (wr_rst),
    .rd_rst   (rd_rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .out_valid(out_valid),
    .cfg_err  (cfg_err),
    .run_mode (run_mode)
);

// File: tb/line_delay_ctrl_bench.sv
module line_delay_ctrl_bench;
    localparam int MAX_LEN  = 24;
    localparam int MIN_FAST = 6;
    localparam int MIN_SLOW = 4;
    localparam int DEF_LEN  = 24;
    localparam int LW       = $clog2(MAX_LEN + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          speed_sel = 1'b0;
    logic          cfg_load = 1'b0;
    logic [LW-1:0] cfg_len = '0;
    logic          wr_rst, rd_rst, wr_en, rd_en, out_valid, cfg_err;
    logic [7:0]    din = 8'd0;

    always #4 clk = ~clk;

    line_delay_ctrl #(
        .MAX_LEN (MAX_LEN),
        .MIN_FAST(MIN_FAST),
        .MIN_SLOW(MIN_SLOW),
        .DEF_LEN (DEF_LEN)
    ) u_line_delay_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode     (mode),
        .speed_sel(speed_sel),
        .cfg_load (cfg_load),
        .cfg_len  (cfg_len),
        .wr_rst   (wr_rst),
        .rd_rst   (rd_rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .out_valid(out_valid),
        .cfg_err  (cfg_err)
    );

    // behavioural line buffer driven by the controls
    logic [7:0] mem [MAX_LEN];
    logic [7:0] hist [64];
    logic [7:0] mod_dout = 8'd0;
    int         wp = 0, rp = 0, ecount = 0;
    logic       rec_wr_rst = 0, rec_rd_rst = 0, rec_wr_en = 0, rec_rd_en = 0;

    always @(posedge clk) begin
        int wa, ra;
        wa = wr_rst ? 0 : wp;
        ra = rd_rst ? 0 : rp;
        if (wr_en) mem[wa] <= din;
        if (rd_en) mod_dout <= mem[ra];
        wp <= wr_en ? ((wa + 1) % MAX_LEN) : wa;
        rp <= rd_en ? ((ra + 1) % MAX_LEN) : ra;
        hist[ecount % 64] <= din;
        rec_wr_rst <= wr_rst;
        rec_rd_rst <= rd_rst;
        rec_wr_en  <= wr_en;
        rec_rd_en  <= rd_en;
        ecount     <= ecount + 1;
    end

    int    n_checks = 0, n_fail = 0;
    int    cur_n = DEF_LEN, cur_md = 0, s0 = 0, held_n = DEF_LEN;
    bit    running = 1'b0, done = 1'b0;
    string ctx = "";
    int    wd = 0;

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, got %0d cycles expected below 150000", wd);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s%s %s: got %0d expected %0d (mode %0d n %0d)",
                     req, ctx, what, act, exp, cur_md, cur_n);
        end
    endtask

    // per-edge check of the running sequence against step arithmetic
    task automatic check_cycle();
        int    e, k;
        bit    joint, xw, xr, xre;
        string rq;
        e = ecount - 1;
        k = e - s0;
        joint = (cur_md == 0) || (cur_md == 3);
        if (joint) begin
            xw = ((k % cur_n) == 0) && ((cur_n != MAX_LEN) || (k == 0));
            xr = xw;
            rq = (cur_n == MAX_LEN) ? "R6" : "R5";
        end else begin
            xw = (k == 0);
            xr = (cur_md == 1) ? (k == cur_n) : (k == 0);
            rq = (cur_md == 1) ? "R7" : "R8";
        end
        xre = (cur_md == 2) ? (k >= cur_n) : 1'b1;
        chk(rec_wr_rst == xw, rq, "wr_rst", int'(rec_wr_rst), int'(xw));
        chk(rec_rd_rst == xr, rq, "rd_rst", int'(rec_rd_rst), int'(xr));
        chk(rec_wr_en == 1'b1, rq, "wr_en", int'(rec_wr_en), 1);
        chk(rec_rd_en == xre, rq, "rd_en", int'(rec_rd_en), int'(xre));
        chk(out_valid == (k >= cur_n), "R9", "out_valid", int'(out_valid), int'(k >= cur_n));
        if (k >= cur_n)
            chk(mod_dout == hist[(e - cur_n) % 64], "R10", "delayed word",
                int'(mod_dout), int'(hist[(e - cur_n) % 64]));
    endtask

    task automatic tick();
        @(negedge clk);
        if (running) check_cycle();
        din = 8'((ecount * 37 + 11) ^ (ecount >> 3));
    endtask

    task automatic load_len(input int n, input bit fast, input bit exp_ok);
        cfg_len   = LW'(n);
        speed_sel = fast;
        cfg_load  = 1'b1;
        tick();
        cfg_load  = 1'b0;
        chk(cfg_err == !exp_ok, exp_ok ? "R2" : "R3", "cfg_err", int'(cfg_err), int'(!exp_ok));
        if (exp_ok) held_n = n;
    endtask

    task automatic start_run(input int md);
        start = 1'b1;
        mode  = 2'(md);
        tick();
        start   = 1'b0;
        cur_n   = held_n;
        cur_md  = md;
        s0      = ecount;
        running = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(!(wr_rst || rd_rst || wr_en || rd_en), "R1", "controls idle",
                int'({wr_rst, rd_rst, wr_en, rd_en}), 0);
            chk(out_valid == 1'b0, "R1", "out_valid idle", int'(out_valid), 0);
            chk(cfg_err == 1'b0, "R1", "cfg_err idle", int'(cfg_err), 0);
        end

        // range edges under both speed settings
        load_len(MIN_SLOW - 1, 0, 0);
        load_len(MAX_LEN + 1, 0, 0);
        load_len(MIN_FAST - 1, 1, 0);   // legal only at the slow minimum: R3
        // held length is still the default (full line): R3 and R6
        start_run(0);
        repeat (3 * MAX_LEN) tick();

        load_len(MIN_FAST, 1, 1);
        load_len(MAX_LEN, 1, 1);
        load_len(MIN_FAST - 1, 0, 1);
        start_run(2);
        repeat (3 * held_n + 4) tick();

        // a load while running must not change the running delay: R4
        ctx = "/R4";
        load_len(9, 0, 1);
        repeat (12) tick();
        start_run(1);
        repeat (30) tick();

        // load and start on the same edge: start takes the old length (R4)
        cfg_len  = LW'(11);
        cfg_load = 1'b1;
        start    = 1'b1;
        mode     = 2'd0;
        tick();
        cfg_load = 1'b0;
        start    = 1'b0;
        cur_n    = held_n;
        cur_md   = 0;
        s0       = ecount;
        held_n   = 11;
        repeat (30) tick();
        start_run(2);
        repeat (30) tick();
        ctx = "";

        // sweep all legal lengths in every mode code
        for (int md = 0; md < 4; md++) begin
            for (int n = MIN_SLOW; n <= MAX_LEN; n++) begin
                load_len(n, 0, 1);
                start_run(md);
                repeat (2 * n + 4) tick();
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule